// File: doc/BRIEF.md
# Sliding Haar Wavelet Decomposer

This block turns a stream of signed speech samples into a three-level Haar decomposition of the most recent `L` samples. It is meant to sit in front of a transform-domain adaptive filter. That filter needs a de-correlated view of its input window, and it needs this view refreshed as the stream advances. The transform uses coefficients of plus or minus one only, so every level is built from one adder and one subtractor.

Each accepted sample enters level 1. Level 1 pairs consecutive samples. It emits the pair sum as its low band and the older-minus-newer difference as its high band. Each later level does the same thing to the low band of the level before it, so it runs at half that level's rate. With a sample on every clock, level 1 produces a result every 2nd clock, level 2 every 4th and level 3 every 8th. Each band result is shifted into a tapped register chain of its own. The chains therefore hold the complete transformed vector of the window, and `out_valid` marks the cycles in which that vector covers exactly the last `L` accepted samples. All rate enables come from one phase counter that advances on accepted samples. A synchronous reset clears the counter and every chain.

Top module: `haar_window_decomp`

## Requirements
- R1: While `rst` is high, and in the first cycle after it is released, `out_valid` is 0 and every bit of `out_vec` is 0.
- R2: Slots 0 to L/2-1 of `out_vec` hold the level-1 high band, one value per sample pair. Each value is the older sample minus the newer sample. Slot 0 holds the newest pair, and slot number rises with the age of the pair.
- R3: Slots L/2 to 3L/4-1 hold the level-2 high band, one value per group of 4 samples. Each value is the sum of the older two samples minus the sum of the newer two. The newest group is in the lowest slot.
- R4: Slots 3L/4 to 7L/8-1 hold the level-3 high band, one value per group of 8 samples. Each value is the sum of the older four samples minus the sum of the newer four. Slots 7L/8 to L-1 hold the level-3 low band, which is the sum of each group of 8. In both bands the newest group is in the lowest slot.
- R5: `out_valid` is a one-cycle pulse. It appears in the cycle after the clock edge that accepts a sample whose count since reset is a multiple of 8, and only once at least L samples have been accepted.
- R6: A cycle with `in_valid` low has no effect. `out_vec` and the pairing phase stay unchanged whatever value is on `in_sample`.
- R7: Slot j occupies bits [j*OUT_W +: OUT_W], with OUT_W = IN_W+3. Each slot is two's complement and sign-extended. Full-scale inputs of either sign produce exact results with no wrap-around.
- R8: At every `out_valid` pulse, the vector is the decomposition of exactly the last L accepted samples. Older samples have left the window.
- R9: A reset in the middle of the stream discards any half-formed pair or group. The first sample after reset becomes the oldest member of a new group of 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Sample on `in_sample` is accepted this cycle |
| in_sample | input | IN_W | Signed input sample |
| out_valid | output | 1 | `out_vec` covers exactly the last L samples this cycle |
| out_vec | output | L*(IN_W+3) | Transformed vector: level-1, level-2 and level-3 high bands, then the level-3 low band |

## Verification
A pairing phase that is off by even one sample pairs the wrong neighbours. It also moves the `out_valid` pulse to the wrong sample, so the bench checks the pulse after every single sample, and a phase error shows at the very next multiple of 8. A chain that shifts at the wrong rate, or is wired in the wrong order, corrupts specific slots at the first pulse after the window fills. Each slot is compared against sums computed in the bench, so the failing slot and the level it belongs to are both visible. State that survives a reset, or that moves during idle cycles, shows as non-zero slots right after reset or as a vector that changes while `in_valid` is low.

// File: rtl/haar_decomp_pkg.sv
package haar_decomp_pkg;

   // First slot of the high band of level lvl (1-based) in the output vector.
   function automatic int hi_slot_base(input int win, input int lvl);
      return win - (win >>> (lvl - 1));
   endfunction

   // First slot of the low band kept from the deepest level.
   function automatic int lo_slot_base(input int win, input int levels);
      return win - (win >>> levels);
   endfunction

   // Number of stored results of one band at level lvl.
   function automatic int band_depth(input int win, input int lvl);
      return win >>> lvl;
   endfunction

endpackage

// File: rtl/haar_delay_line.sv
module haar_delay_line #(
   parameter int W     = 17,
   parameter int DEPTH = 4
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               shift,
   input  logic [W-1:0]       din,
   output logic [DEPTH*W-1:0] taps
);

   if (DEPTH < 1) begin : g_bad_depth
      $error("haar_delay_line: DEPTH must be at least 1");
   end

   logic [W-1:0] stage_q [DEPTH];

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int i = 0; i < DEPTH; i++) stage_q[i] <= '0;
      end else if (shift) begin
         stage_q[0] <= din;
         for (int i = 1; i < DEPTH; i++) stage_q[i] <= stage_q[i-1];
      end
   end

   for (genvar i = 0; i < DEPTH; i++) begin : g_tap
      assign taps[i*W +: W] = stage_q[i];
   end

endmodule

// File: rtl/haar_pair_stage.sv
module haar_pair_stage #(
   parameter int IW    = 16,
   parameter int DEPTH = 4
) (
   input  logic                       clk,
   input  logic                       rst,
   input  logic                       strobe,
   input  logic                       second,
   input  logic signed [IW-1:0]       din,
   output logic signed [IW:0]         lo_out,
   output logic [DEPTH*(IW+1)-1:0]    hi_taps
);

   localparam int OW = IW + 1;

   logic signed [IW-1:0] held_q;
   logic signed [OW-1:0] older_x;
   logic signed [OW-1:0] newer_x;
   logic signed [OW-1:0] hi_val;
   logic                 pair_end;

   assign older_x  = OW'(held_q);
   assign newer_x  = OW'(din);
   assign lo_out   = older_x + newer_x;
   assign hi_val   = older_x - newer_x;
   assign pair_end = strobe & second;

   always_ff @(posedge clk) begin
      if (rst) begin
         held_q <= '0;
      end else if (strobe && !second) begin
         held_q <= din;
      end
   end

   haar_delay_line #(
      .W     (OW),
      .DEPTH (DEPTH)
   ) u_hi_chain (
      .clk   (clk),
      .rst   (rst),
      .shift (pair_end),
      .din   (hi_val),
      .taps  (hi_taps)
   );

endmodule

// File: rtl/haar_phase_ctrl.sv
module haar_phase_ctrl #(
   parameter int LEVELS = 3,
   parameter int NBLK   = 1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              in_valid,
   output logic [LEVELS-1:0] phase,
   output logic [LEVELS:0]   stage_en,
   output logic              out_valid
);

   localparam int FW = $clog2(NBLK + 1);

   logic [FW-1:0] fill_q;
   logic          run_and;

   always_comb begin
      run_and     = in_valid;
      stage_en[0] = in_valid;
      for (int k = 1; k <= LEVELS; k++) begin
         run_and     = run_and & phase[k-1];
         stage_en[k] = run_and;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         phase     <= '0;
         fill_q    <= '0;
         out_valid <= 1'b0;
      end else begin
         out_valid <= stage_en[LEVELS] && (fill_q >= FW'(NBLK - 1));
         if (in_valid) phase <= phase + 1'b1;
         if (stage_en[LEVELS] && (fill_q != FW'(NBLK))) fill_q <= fill_q + 1'b1;
      end
   end

endmodule

// File: rtl/haar_window_decomp.sv
module haar_window_decomp
   import haar_decomp_pkg::*;
#(
   parameter int IN_W   = 16,
   parameter int L      = 8,
   parameter int LEVELS = 3
) (
   input  logic                          clk,
   input  logic                          rst,
   input  logic                          in_valid,
   input  logic [IN_W-1:0]               in_sample,
   output logic                          out_valid,
   output logic [L*(IN_W+LEVELS)-1:0]    out_vec
);

   localparam int OUT_W = IN_W + LEVELS;
   localparam int GROUP = 1 << LEVELS;
   localparam int NBLK  = L / GROUP;
   localparam int LBASE = lo_slot_base(L, LEVELS);

   if (LEVELS < 3) begin : g_bad_levels
      $error("haar_window_decomp: at least three levels are required");
   end
   if ((L % GROUP) != 0 || L < GROUP) begin : g_bad_window
      $error("haar_window_decomp: L must be a non-zero multiple of 2**LEVELS");
   end
   if (IN_W < 2) begin : g_bad_width
      $error("haar_window_decomp: IN_W must be at least 2");
   end

   logic [LEVELS-1:0] phase;
   logic [LEVELS:0]   stage_en;

   haar_phase_ctrl #(
      .LEVELS (LEVELS),
      .NBLK   (NBLK)
   ) u_ctrl (
      .clk       (clk),
      .rst       (rst),
      .in_valid  (in_valid),
      .phase     (phase),
      .stage_en  (stage_en),
      .out_valid (out_valid)
   );

   for (genvar k = 1; k <= LEVELS; k++) begin : g_lvl
      localparam int IW   = IN_W + k - 1;
      localparam int OW   = IW + 1;
      localparam int D    = band_depth(L, k);
      localparam int BASE = hi_slot_base(L, k);

      logic signed [IW-1:0] din_k;
      logic signed [OW-1:0] lo_k;
      logic [D*OW-1:0]      hi_k;

      if (k == 1) begin : g_src
         assign din_k = $signed(in_sample);
      end else begin : g_src
         assign din_k = g_lvl[k-1].lo_k;
      end

      haar_pair_stage #(
         .IW    (IW),
         .DEPTH (D)
      ) u_stage (
         .clk     (clk),
         .rst     (rst),
         .strobe  (stage_en[k-1]),
         .second  (phase[k-1]),
         .din     (din_k),
         .lo_out  (lo_k),
         .hi_taps (hi_k)
      );

      for (genvar j = 0; j < D; j++) begin : g_slot
         logic signed [OW-1:0] band_v;
         assign band_v = $signed(hi_k[j*OW +: OW]);
         assign out_vec[(BASE+j)*OUT_W +: OUT_W] = OUT_W'(band_v);
      end
   end

   logic [NBLK*OUT_W-1:0] lo_taps;

   haar_delay_line #(
      .W     (OUT_W),
      .DEPTH (NBLK)
   ) u_lo_chain (
      .clk   (clk),
      .rst   (rst),
      .shift (stage_en[LEVELS]),
      .din   (g_lvl[LEVELS].lo_k),
      .taps  (lo_taps)
   );

   assign out_vec[LBASE*OUT_W +: NBLK*OUT_W] = lo_taps;

endmodule

// File: rtl/haar_window_decomp_chk.sv
module haar_window_decomp_chk #(
   parameter int IN_W   = 16,
   parameter int L      = 8,
   parameter int LEVELS = 3
) (
   input logic                          clk,
   input logic                          rst,
   input logic                          in_valid,
   input logic [IN_W-1:0]               in_sample,
   input logic                          out_valid,
   input logic [L*(IN_W+LEVELS)-1:0]    out_vec
);

   localparam int OUT_W = IN_W + LEVELS;
   localparam int GROUP = 1 << LEVELS;
   localparam int LBASE = L - (L >>> LEVELS);
   localparam int CW    = $clog2(L + 1);

   logic signed [IN_W-1:0]  seen_q [GROUP];
   logic [CW-1:0]           accepted_q;
   logic signed [OUT_W-1:0] group_sum;
   logic signed [OUT_W-1:0] newest_diff;
   logic signed [OUT_W-1:0] slot0_v;
   logic signed [OUT_W-1:0] low0_v;

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int i = 0; i < GROUP; i++) seen_q[i] <= '0;
         accepted_q <= '0;
      end else if (in_valid) begin
         seen_q[0] <= $signed(in_sample);
         for (int i = 1; i < GROUP; i++) seen_q[i] <= seen_q[i-1];
         if (accepted_q != CW'(L)) accepted_q <= accepted_q + 1'b1;
      end
   end

   always_comb begin
      group_sum = '0;
      for (int i = 0; i < GROUP; i++) group_sum = group_sum + OUT_W'(seen_q[i]);
   end

   assign newest_diff = OUT_W'(seen_q[1]) - OUT_W'(seen_q[0]);
   assign slot0_v     = $signed(out_vec[OUT_W-1:0]);
   assign low0_v      = $signed(out_vec[LBASE*OUT_W +: OUT_W]);

   // R1: reset leaves the outputs cleared
   p_reset_clear_r1: assert property (@(posedge clk)
      $past(rst) |-> (!out_valid && out_vec == '0));

   // R2: the newest level-1 slot is older minus newer of the last pair
   p_newest_diff_r2: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> (slot0_v == newest_diff));

   // R4: the newest low slot is the sum of the last group
   p_group_sum_r4: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> (low0_v == group_sum));

   // R5: a pulse follows an accepted sample
   p_pulse_follows_sample_r5: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> $past(in_valid));

   // R5: the pulse lasts a single cycle
   p_single_pulse_r5: assert property (@(posedge clk) disable iff (rst)
      out_valid |=> !out_valid);

   // R5: no pulse before a full window has been accepted
   p_window_filled_r5: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> (accepted_q >= CW'(L)));

   // R6: an idle cycle leaves the vector untouched
   p_idle_hold_r6: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> $stable(out_vec));

endmodule

bind haar_window_decomp haar_window_decomp_chk #(
   .IN_W   (IN_W),
   .L      (L),
   .LEVELS (LEVELS)
) u_chk (
   .clk       (clk),
   .rst       (rst),
   .in_valid  (in_valid),
   .in_sample (in_sample),
   .out_valid (out_valid),
   .out_vec   (out_vec)
);

// File: tb/haar_window_decomp_tb_top.sv
`timescale 1ns/1ps
module haar_window_decomp_tb_top;

   localparam int IN_W   = 16;
   localparam int L      = 8;
   localparam int LEVELS = 3;
   localparam int OW     = IN_W + LEVELS;
   localparam int GROUP  = 1 << LEVELS;

   logic              clk = 1'b0;
   logic              rst = 1'b1;
   logic              in_valid = 1'b0;
   logic [IN_W-1:0]   in_sample = '0;
   logic              out_valid;
   logic [L*OW-1:0]   out_vec;

   int checks   = 0;
   int failures = 0;
   bit done     = 1'b0;

   int win [L];
   int accepted = 0;

   always #2 clk = ~clk;

   haar_window_decomp #(
      .IN_W   (IN_W),
      .L      (L),
      .LEVELS (LEVELS)
   ) dut_i (
      .clk       (clk),
      .rst       (rst),
      .in_valid  (in_valid),
      .in_sample (in_sample),
      .out_valid (out_valid),
      .out_vec   (out_vec)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int grp_sum(input int lo, input int n);
      int s = 0;
      for (int i = 0; i < n; i++) s += win[lo + i];
      return s;
   endfunction

   // Expected slot value from the window model (win[L-1] newest).
   function automatic int exp_slot(input int j);
      for (int k = 1; k <= LEVELS; k++) begin
         int base = L - (L >>> (k - 1));
         int d    = L >>> k;
         int g    = 1 << k;
         if (j >= base && j < base + d) begin
            int first = L - g * (j - base + 1);
            return grp_sum(first, g/2) - grp_sum(first + g/2, g/2);
         end
      end
      return grp_sum(L - GROUP * (j - (L - (L >>> LEVELS)) + 1), GROUP);
   endfunction

   function automatic int act_slot(input int j);
      logic signed [OW-1:0] v;
      v = out_vec[j*OW +: OW];
      return int'(v);
   endfunction

   task automatic check_vec(input string req);
      for (int j = 0; j < L; j++) begin
         check(act_slot(j) == exp_slot(j), req, act_slot(j), exp_slot(j));
      end
   endtask

   task automatic do_reset();
      rst = 1'b1;
      in_valid = 1'b0;
      @(negedge clk);
      @(negedge clk);
      rst = 1'b0;
      accepted = 0;
      for (int i = 0; i < L; i++) win[i] = 0;
   endtask

   // Drives one sample, then checks out_valid (R5) and the vector on a pulse.
   task automatic send(input int v, input string req);
      logic signed [IN_W-1:0] t;
      bit exp_v;
      t = v[IN_W-1:0];
      in_sample = t;
      in_valid  = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      for (int i = 0; i < L - 1; i++) win[i] = win[i+1];
      win[L-1] = int'(t);
      accepted++;
      exp_v = (accepted % GROUP == 0) && (accepted >= L);
      check(out_valid == exp_v, "R5 pulse position", int'(out_valid), int'(exp_v));
      if (exp_v) check_vec(req);
   endtask

   task automatic idle(input int n, input int junk);
      for (int i = 0; i < n; i++) begin
         in_sample = junk[IN_W-1:0] ^ IN_W'(i * 4099);
         @(negedge clk);
         check(out_valid == 1'b0, "R6 no pulse when idle", int'(out_valid), 0);
      end
   endtask

   task automatic t_reset_state();
      do_reset();
      check(out_valid == 1'b0, "R1 out_valid after reset", int'(out_valid), 0);
      check(out_vec == '0, "R1 vector after reset", int'(out_vec != '0), 0);
   endtask

   task automatic t_ramp();
      // R2 R3 R4 R8: two consecutive windows of a ramp
      for (int i = 0; i < 16; i++) send(i * 37 - 100, "R2 R3 R4 R8 ramp");
   endtask

   task automatic t_extremes();
      // R7: full-scale values of both signs
      for (int i = 0; i < 4; i++) send(32767, "R7 max-then-min");
      for (int i = 0; i < 4; i++) send(-32768, "R7 max-then-min");
      for (int i = 0; i < 8; i++) send((i % 2 == 0) ? -32768 : 32767, "R7 alternating");
      for (int i = 0; i < 8; i++) send(-32768, "R7 all minimum");
   endtask

   task automatic t_gaps();
      logic [L*OW-1:0] snap;
      // R6: idle cycles with junk data between samples
      for (int i = 0; i < 8; i++) begin
         send(1000 - i * 311, "R6 gapped stream");
         idle(i % 3, 16'h5a5a);
      end
      snap = out_vec;
      idle(6, 16'h7fff);
      check(out_vec == snap, "R6 vector held while idle", int'(out_vec != snap), 0);
      for (int i = 0; i < 8; i++) send(i * i - 20, "R6 after idle");
   endtask

   task automatic t_midreset();
      // R9: partial group discarded
      for (int i = 0; i < 3; i++) send(500 + i, "R9 before reset");
      do_reset();
      check(out_vec == '0, "R1 R9 vector cleared mid-stream", int'(out_vec != '0), 0);
      for (int i = 0; i < 8; i++) send(-7 * i + 3, "R9 regrouped after reset");
   endtask

   task automatic t_random();
      int s = 32'h1234_5678;
      // R8: sliding windows of pseudo-random speech-like data
      for (int i = 0; i < 40; i++) begin
         s = s * 1103515245 + 12345;
         send(int'($signed(s[23:8])), "R8 random windows");
      end
   endtask

   initial begin
      for (int i = 0; i < L; i++) win[i] = 0;
      @(negedge clk);
      t_reset_state();
      t_ramp();
      t_extremes();
      t_gaps();
      t_midreset();
      t_random();
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         failures++;
         checks++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule